// File: doc/BRIEF.md
# ADC calibration mode sequencer

This block is the control state machine that sits beside a delta-sigma converter's modulator and decimation filter. It takes a 3-bit calibration mode code, which software writes as a one-cycle pulse. From that code it steers the analog input multiplexer between three sources: the external input pins, an internally shorted input pair, and the internal reference node. Each time the source changes, it asks the filter to restart. It then counts filter results: the first few after every switch are thrown away while the filter settles, and the next one is the measurement that belongs to the current step.

Every measurement it keeps is reported with a one-cycle result strobe. A tag marks the result as either a calibration point or a normal sample. Calibration points can also strobe the zero-scale coefficient latch, the full-scale coefficient latch, or both. The active-low data-ready output stays high for the whole of a calibration sequence. It falls only when a normal sample is produced, which means the coefficients have been updated and the filter has settled back on the external input.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset, `mux_sel` is 00 (external input), `drdy_n` is high, and `conv_start`, `res_valid`, `zs_latch` and `fs_latch` are low. The multiplexer encoding is 00 external, 01 shorted inputs, 10 reference node.
- R2: A mode write with any code aborts whatever sequence is running and starts the sequence for the new code. In the cycle after the write, `conv_start` is high for one cycle and `drdy_n` is high.
- R3: After every `conv_start`, the first `settle_len` conversion-done pulses produce no result. A `settle_len` of 0 keeps the first pulse. Whenever `mux_sel` changes, `conv_start` is high in that same cycle.
- R4: Codes 000, 110 and 111 select normal mode on the external input. In normal mode, each kept conversion gives `res_valid` with `res_cal` low and drives `drdy_n` low. `drdy_n` stays low until the next mode write or the next conversion-done pulse that does not give a normal result.
- R5: Code 001 (self-calibration) measures the shorted inputs (mux 01) with no coefficient strobe. It then restarts on the reference node (mux 10) and measures with `zs_latch` and `fs_latch` together. After that it returns to normal mode on the external input.
- R6: Code 010 measures the external input once, strobes only `zs_latch`, and then continues in normal mode with no multiplexer switch. The full-scale coefficient is therefore left untouched.
- R7: Code 011 measures the external input once, strobes only `fs_latch`, and then continues in normal mode with no multiplexer switch.
- R8: Code 100 (system offset) measures the external input with no strobe. It then restarts on the reference node and measures with both strobes, then returns to normal mode on the external input.
- R9: Code 101 (background) repeats the same cycle until the next mode write: a normal result on the external input, then a shorted-input point with `zs_latch`, then a reference point with `fs_latch`. With `settle_len` = 1, exactly one of every six conversion-done pulses yields a normal result.
- R10: The first normal result after background mode is entered has `res_bad` high. Every later result has `res_bad` low.
- R11: `drdy_n` falls only in a cycle where a normal result (`res_valid` high, `res_cal` low) is reported, and it is high on every calibration point.
- R12: The result strobes are registered. They appear in the cycle after the conversion-done pulse that produced them and last exactly one cycle.
- R13: A conversion-done pulse in the same cycle as a mode write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle pulse: load a new mode code |
| mode_code | input | 3 | Calibration mode code |
| settle_len | input | SETTLE_W | Number of results discarded after each filter restart |
| conv_done | input | 1 | One-cycle pulse from the filter: a conversion result is ready |
| mux_sel | output | 2 | Input multiplexer select (00 external, 01 shorted, 10 reference) |
| conv_start | output | 1 | One-cycle filter restart request |
| zs_latch | output | 1 | Latch the zero-scale coefficient |
| fs_latch | output | 1 | Latch the full-scale coefficient |
| res_valid | output | 1 | A kept conversion is reported this cycle |
| res_cal | output | 1 | The reported conversion is a calibration point |
| res_bad | output | 1 | The reported normal result is not yet calibrated |
| drdy_n | output | 1 | Active-low data ready |

## Verification
The properties assume that `mode_wr` and `conv_done` are single-cycle pulses sampled on the rising edge. They also assume that `settle_len` does not change while a sequence is counting discards, since the sequencer compares against it live. The bench drives every input on the falling edge, changes `settle_len` only before issuing a mode write, and plays the filter itself by pulsing `conv_done` one cycle at a time. Back-to-back pulses are allowed, and one test places a pulse in the same cycle as a mode write on purpose.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] CODE_NORMAL     = 3'b000;
    localparam logic [MODE_W-1:0] CODE_SELF       = 3'b001;
    localparam logic [MODE_W-1:0] CODE_SYS_ZERO   = 3'b010;
    localparam logic [MODE_W-1:0] CODE_SYS_FULL   = 3'b011;
    localparam logic [MODE_W-1:0] CODE_SYS_OFFSET = 3'b100;
    localparam logic [MODE_W-1:0] CODE_BACKGROUND = 3'b101;

    typedef enum logic [1:0] {
        MUX_EXT   = 2'b00,
        MUX_SHORT = 2'b01,
        MUX_REF   = 2'b10
    } mux_e;

    typedef enum logic [3:0] {
        PH_NORM,
        PH_SC_ZERO,
        PH_SC_FULL,
        PH_SYS_ZERO,
        PH_SYS_FULL,
        PH_OFS_ZERO,
        PH_OFS_FULL,
        PH_BG_EXT,
        PH_BG_ZERO,
        PH_BG_FULL
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   bg_first;
        logic   conv_start;
        logic   res_valid;
        logic   res_cal;
        logic   res_bad;
        logic   zs_latch;
        logic   fs_latch;
        logic   drdy_n;
    } seq_state_t;

    // Input source that each phase measures.
    function automatic mux_e phase_mux(input phase_e p);
        case (p)
            PH_SC_ZERO, PH_BG_ZERO:              return MUX_SHORT;
            PH_SC_FULL, PH_OFS_FULL, PH_BG_FULL: return MUX_REF;
            default:                             return MUX_EXT;
        endcase
    endfunction

endpackage

// File: rtl/adc_cal_mode_decode.sv
module adc_cal_mode_decode
    import adc_cal_pkg::*;
(
    input  logic [MODE_W-1:0] mode_code,
    output phase_e            start_phase
);

    always_comb begin
        case (mode_code)
            CODE_SELF:       start_phase = PH_SC_ZERO;
            CODE_SYS_ZERO:   start_phase = PH_SYS_ZERO;
            CODE_SYS_FULL:   start_phase = PH_SYS_FULL;
            CODE_SYS_OFFSET: start_phase = PH_OFS_ZERO;
            CODE_BACKGROUND: start_phase = PH_BG_EXT;
            // CODE_NORMAL and the two spare codes
            default:         start_phase = PH_NORM;
        endcase
    end

endmodule

// File: rtl/adc_cal_settle_gate.sv
module adc_cal_settle_gate #(
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                conv_done,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                take
);

    logic [SETTLE_W-1:0] cnt_d, cnt_q;
    logic                settled;

    always_comb begin
        settled = (cnt_q >= settle_len);
        take    = conv_done && settled;
        cnt_d   = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (conv_done && !settled) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adc_cal_pkg::*;
#(
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wr,
    input  logic [2:0]          mode_code,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                conv_done,
    output logic [1:0]          mux_sel,
    output logic                conv_start,
    output logic                zs_latch,
    output logic                fs_latch,
    output logic                res_valid,
    output logic                res_cal,
    output logic                res_bad,
    output logic                drdy_n
);

    seq_state_t s_d, s_q;
    phase_e     start_phase;
    logic       take;
    logic       restart;

    adc_cal_mode_decode u_decode (
        .mode_code   (mode_code),
        .start_phase (start_phase)
    );

    adc_cal_settle_gate #(
        .SETTLE_W (SETTLE_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .conv_done  (conv_done),
        .settle_len (settle_len),
        .take       (take)
    );

    always_comb begin
        s_d           = s_q;
        s_d.res_valid = 1'b0;
        s_d.res_cal   = 1'b0;
        s_d.res_bad   = 1'b0;
        s_d.zs_latch  = 1'b0;
        s_d.fs_latch  = 1'b0;
        restart       = 1'b0;

        if (mode_wr) begin
            // New code: drop the running sequence and the pending result.
            s_d.phase    = start_phase;
            s_d.bg_first = 1'b1;
            s_d.drdy_n   = 1'b1;
            restart      = 1'b1;
        end else if (conv_done && !take) begin
            // Settling result: discarded.
            s_d.drdy_n = 1'b1;
        end else if (take) begin
            s_d.res_valid = 1'b1;
            unique case (s_q.phase)
                PH_NORM: begin
                    s_d.drdy_n = 1'b0;
                end
                PH_SC_ZERO: begin
                    s_d.res_cal = 1'b1;
                    s_d.phase   = PH_SC_FULL;
                end
                PH_SC_FULL: begin
                    s_d.res_cal  = 1'b1;
                    s_d.zs_latch = 1'b1;
                    s_d.fs_latch = 1'b1;
                    s_d.phase    = PH_NORM;
                end
                PH_SYS_ZERO: begin
                    s_d.res_cal  = 1'b1;
                    s_d.zs_latch = 1'b1;
                    s_d.phase    = PH_NORM;
                end
                PH_SYS_FULL: begin
                    s_d.res_cal  = 1'b1;
                    s_d.fs_latch = 1'b1;
                    s_d.phase    = PH_NORM;
                end
                PH_OFS_ZERO: begin
                    s_d.res_cal = 1'b1;
                    s_d.phase   = PH_OFS_FULL;
                end
                PH_OFS_FULL: begin
                    s_d.res_cal  = 1'b1;
                    s_d.zs_latch = 1'b1;
                    s_d.fs_latch = 1'b1;
                    s_d.phase    = PH_NORM;
                end
                PH_BG_EXT: begin
                    s_d.drdy_n   = 1'b0;
                    s_d.res_bad  = s_q.bg_first;
                    s_d.bg_first = 1'b0;
                    s_d.phase    = PH_BG_ZERO;
                end
                PH_BG_ZERO: begin
                    s_d.res_cal  = 1'b1;
                    s_d.zs_latch = 1'b1;
                    s_d.phase    = PH_BG_FULL;
                end
                PH_BG_FULL: begin
                    s_d.res_cal  = 1'b1;
                    s_d.fs_latch = 1'b1;
                    s_d.phase    = PH_BG_EXT;
                end
                default: begin
                    s_d.phase = PH_NORM;
                end
            endcase
            if (s_d.res_cal) begin
                s_d.drdy_n = 1'b1;
            end
            // A source change needs a fresh filter.
            restart = (phase_mux(s_d.phase) != phase_mux(s_q.phase));
        end

        s_d.conv_start = restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_NORM, drdy_n: 1'b1, default: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mux_sel    = phase_mux(s_q.phase);
    assign conv_start = s_q.conv_start;
    assign zs_latch   = s_q.zs_latch;
    assign fs_latch   = s_q.fs_latch;
    assign res_valid  = s_q.res_valid;
    assign res_cal    = s_q.res_cal;
    assign res_bad    = s_q.res_bad;
    assign drdy_n     = s_q.drdy_n;

endmodule

// File: rtl/adc_cal_sequencer_chk.sv
module adc_cal_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic [2:0] mode_code,
    input logic       conv_done,
    input logic [1:0] mux_sel,
    input logic       conv_start,
    input logic       zs_latch,
    input logic       fs_latch,
    input logic       res_valid,
    input logic       res_cal,
    input logic       res_bad,
    input logic       drdy_n
);

    // R2
    write_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> conv_start && drdy_n && !res_valid);

    // R3
    mux_switch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel) |-> conv_start);

    // R4
    spare_code_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_code[2:1] == 2'b11) |=> (mux_sel == 2'b00));

    // R5
    coef_strobe_on_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zs_latch || fs_latch) |-> (res_valid && res_cal));

    // R10
    bad_flag_normal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_bad |-> (res_valid && !res_cal));

    // R11
    drdy_fall_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> (res_valid && !res_cal));

    // R11
    drdy_high_on_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_cal) |-> drdy_n);

    // R12
    result_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(conv_done));

    // R13
    done_on_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$past(mode_wr));

endmodule

bind adc_cal_sequencer adc_cal_sequencer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_code  (mode_code),
    .conv_done  (conv_done),
    .mux_sel    (mux_sel),
    .conv_start (conv_start),
    .zs_latch   (zs_latch),
    .fs_latch   (fs_latch),
    .res_valid  (res_valid),
    .res_cal    (res_cal),
    .res_bad    (res_bad),
    .drdy_n     (drdy_n)
);

// File: tb/adc_cal_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_cal_sequencer_tb_top;

    localparam int SETTLE_W = 4;
    localparam int NV       = 9;

    // Per conversion-done pulse: one byte, high nibble = mux expected before
    // the pulse, low nibble = kind (0 discard, 1 normal, 2 cal, 3 cal+zs,
    // 4 cal+fs, 5 cal+both, 6 normal flagged bad). First pulse leftmost.
    localparam logic [2:0]          VM [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd1};
    localparam logic [SETTLE_W-1:0] VS [NV] = '{4'd2, 4'd1, 4'd0, 4'd1, 4'd1, 4'd1, 4'd0, 4'd3, 4'd0};
    localparam int                  VN [NV] = '{4, 6, 3, 3, 6, 10, 2, 4, 3};
    localparam logic [127:0]        VE [NV] = '{
        128'h0000_0101_0000_0000_0000_0000_0000_0000,
        128'h1012_2025_0001_0000_0000_0000_0000_0000,
        128'h0301_0100_0000_0000_0000_0000_0000_0000,
        128'h0004_0100_0000_0000_0000_0000_0000_0000,
        128'h0002_2025_0001_0000_0000_0000_0000_0000,
        128'h0006_1013_2024_0001_1013_0000_0000_0000,
        128'h0101_0000_0000_0000_0000_0000_0000_0000,
        128'h0000_0001_0000_0000_0000_0000_0000_0000,
        128'h1225_0100_0000_0000_0000_0000_0000_0000
    };
    localparam string VR [NV] = '{"R3", "R5", "R6", "R7", "R8", "R9", "R4", "R3", "R5"};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                mode_wr = 1'b0;
    logic [2:0]          mode_code = 3'd0;
    logic [SETTLE_W-1:0] settle_len = '0;
    logic                conv_done = 1'b0;
    logic [1:0]          mux_sel;
    logic                conv_start, zs_latch, fs_latch;
    logic                res_valid, res_cal, res_bad, drdy_n;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    logic [7:0] ev;
    int   kind;
    int   normals;

    always #2.5 clk = ~clk;

    adc_cal_sequencer #(.SETTLE_W(SETTLE_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_code  (mode_code),
        .settle_len (settle_len),
        .conv_done  (conv_done),
        .mux_sel    (mux_sel),
        .conv_start (conv_start),
        .zs_latch   (zs_latch),
        .fs_latch   (fs_latch),
        .res_valid  (res_valid),
        .res_cal    (res_cal),
        .res_bad    (res_bad),
        .drdy_n     (drdy_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_mode(input logic [2:0] code);
        @(negedge clk);
        mode_wr   = 1'b1;
        mode_code = code;
        @(negedge clk);
        mode_wr = 1'b0;
        check("R2", "conv_start after write", int'(conv_start), 1);
        check("R2", "drdy_n after write", int'(drdy_n), 1);
    endtask

    // Called at a falling edge; leaves the bench at the falling edge after.
    task automatic done_pulse();
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "mux_sel in reset", int'(mux_sel), 0);
        check("R1", "drdy_n in reset", int'(drdy_n), 1);
        check("R1", "strobes in reset",
              int'({conv_start, res_valid, zs_latch, fs_latch}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "mux_sel after reset", int'(mux_sel), 0);
        check("R1", "drdy_n after reset", int'(drdy_n), 1);

        // R4: normal mode straight out of reset, settle_len 0
        done_pulse();
        check("R4", "res_valid normal", int'(res_valid), 1);
        check("R4", "res_cal normal", int'(res_cal), 0);
        check("R4", "drdy_n normal", int'(drdy_n), 0);
        // R12: single-cycle strobe, drdy_n holds low
        @(negedge clk);
        check("R12", "res_valid one cycle", int'(res_valid), 0);
        check("R4", "drdy_n held low", int'(drdy_n), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            settle_len = VS[v];
            write_mode(VM[v]);
            normals = 0;
            for (int e = 0; e < VN[v]; e++) begin
                ev   = VE[v][127 - 8*e -: 8];
                kind = int'(ev[3:0]);
                check(VR[v], "mux before pulse", int'(mux_sel), int'(ev[5:4]));
                done_pulse();
                check(VR[v], "res_valid", int'(res_valid), int'(kind != 0));
                check(VR[v], "res_cal", int'(res_cal), int'(kind >= 2 && kind <= 5));
                check(VR[v], "zs_latch", int'(zs_latch), int'(kind == 3 || kind == 5));
                check(VR[v], "fs_latch", int'(fs_latch), int'(kind == 4 || kind == 5));
                check("R10", "res_bad", int'(res_bad), int'(kind == 6));
                check("R11", "drdy_n", int'(drdy_n), int'(!(kind == 1 || kind == 6)));
                if (e >= 2 && e < 8 && res_valid && !res_cal) normals++;
            end
            if (v == 5) check("R9", "normal results per six pulses", normals, 1);
        end

        // R2: abort a running self-calibration
        settle_len = '0;
        write_mode(3'b001);
        done_pulse();
        check("R2", "mux after shorted point", int'(mux_sel), 2);
        write_mode(3'b000);
        check("R2", "mux after abort", int'(mux_sel), 0);
        done_pulse();
        check("R2", "normal after abort", int'({res_valid, res_cal, fs_latch}), 3'b100);
        check("R2", "drdy_n after abort", int'(drdy_n), 0);

        // R13: pulse in the same cycle as a write is dropped
        @(negedge clk);
        mode_wr   = 1'b1;
        mode_code = 3'b000;
        conv_done = 1'b1;
        @(negedge clk);
        mode_wr   = 1'b0;
        conv_done = 1'b0;
        check("R13", "res_valid on write cycle", int'(res_valid), 0);
        check("R13", "conv_start on write cycle", int'(conv_start), 1);
        done_pulse();
        check("R13", "next pulse kept", int'(res_valid), 1);

        // R10: re-entering background flags the first result again
        settle_len = '0;
        write_mode(3'b101);
        done_pulse();
        check("R10", "re-entry first bad", int'(res_bad), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule